// File: doc/BRIEF.md
# Event-Driven Timestamp Counter Unit

This block keeps a receiver's notion of time as two unsigned words: a seconds value and a fast sub-second counter. Decoded 8-bit event codes arrive at one per event-clock cycle. Two special codes build the next seconds value one bit at a time in a shift register. A reset code promotes that value to the seconds output and clears the counter in the same cycle.

The counter advances from one of three sources, chosen by a control input: received increment codes, a free-running divided event clock, or a rising edge on a selected distributed-bus bit. A fourth setting halts it. When the upstream mapping logic flags an event for capture, the block pushes the code and both time words into a 16-entry FIFO. A host drains that FIFO through a valid/ready port.

A separate software latch request copies both time words into readable output registers and leaves the FIFO alone. On the FIFO read port, the head entry is presented whenever `fifo_valid` is high. It is removed on a cycle where `fifo_valid` and `fifo_ready` are both high. While `fifo_ready` is low, the head entry and `fifo_valid` hold steady. The write side has no back-pressure: an entry that arrives while the FIFO is full is dropped, and a sticky overflow flag records the loss.

Top module: `evt_timestamp_unit`

## Requirements
- R1: After reset, `secs`, `ts_count`, `latch_secs` and `latch_count` are 0, `fifo_empty` is 1, and `fifo_full`, `fifo_valid` and `fifo_overflow` are 0.
- R2: Code 0x70 shifts a 0 into the least significant bit of the internal seconds shift register, and code 0x71 shifts in a 1. The `secs` output does not change on either code.
- R3: Code 0x7D copies the shift register into `secs` and clears `ts_count` to 0, both visible after the next clock edge. It takes priority over any increment from the selected source, and it also restarts the clock divider.
- R4: With `cnt_src`=0 (event counting), code 0x7C raises `ts_count` by exactly 1 after the next edge. Every other code except 0x7D leaves `ts_count` unchanged.
- R5: With `cnt_src`=1 (divided clock), `ts_count` rises by 1 once every FREE_DIV cycles. The first step lands FREE_DIV edges after a 0x7D code (4 with defaults). Code 0x7C has no effect in this mode.
- R6: With `cnt_src`=2 (bus clock), `ts_count` rises by 1 per rising edge of `dbus[dbus_sel]`, two clock edges after the edge is first sampled. Other bus bits and code 0x7C have no effect.
- R7: A cycle with `evt_capture`=1 and a nonzero code pushes {code, `secs`, `ts_count`} into the FIFO. The time words are the values on the outputs during that cycle.
- R8: Code 0x00 never changes `secs` or the shift register. It never pushes into the FIFO, even when `evt_capture` is 1.
- R9: The FIFO returns entries in arrival order. While `fifo_valid`=1 and `fifo_ready`=0, the head entry is held stable.
- R10: The FIFO holds 16 entries and raises `fifo_full` at 16. A push while full is dropped and sets `fifo_overflow`, which stays set until reset.
- R11: `sw_latch`=1 copies the current `secs` and `ts_count` into `latch_secs` and `latch_count` after the next edge. It does not write to the FIFO.
- R12: With `cnt_src`=3, `ts_count` holds its value, except that code 0x7D still clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Event clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_code | input | 8 | Decoded event code, one per cycle |
| evt_capture | input | 1 | Upstream mapping flags this code for FIFO capture |
| cnt_src | input | 2 | Counter source: 0 events, 1 divided clock, 2 bus bit, 3 halt |
| dbus | input | DBUS_W | Distributed-bus bits |
| dbus_sel | input | $clog2(DBUS_W) | Index of the bus bit used as counter clock |
| sw_latch | input | 1 | Software request to latch both time words |
| secs | output | TIME_W | Current seconds value |
| ts_count | output | TIME_W | Current sub-second counter |
| latch_secs | output | TIME_W | Seconds captured by a software latch |
| latch_count | output | TIME_W | Counter captured by a software latch |
| fifo_valid | output | 1 | FIFO head entry is present |
| fifo_ready | input | 1 | Host accepts the head entry |
| fifo_code | output | 8 | Head entry event code |
| fifo_secs | output | TIME_W | Head entry seconds |
| fifo_count | output | TIME_W | Head entry counter |
| fifo_full | output | 1 | FIFO holds FIFO_DEPTH entries |
| fifo_empty | output | 1 | FIFO holds no entries |
| fifo_overflow | output | 1 | Sticky: a push was dropped while full |

## Verification
A vector table drives an interleaved stream of shift, increment, null, reset and user codes in event-counting mode. This tells apart a shift applied to the wrong end, a shift that leaks straight into `secs`, and capture words taken after the update instead of before it. Directed runs then exercise each counter source with decoy stimulus. A 0x7C code is sent in the divided and bus modes, and a non-selected bus bit is toggled, so that a wrong source multiplexer shows up as an extra count. The FIFO is filled past its depth and drained under stalls, which separates ordering, head stability and drop-on-full behaviour. A software latch is issued on a cycle that also increments the counter, which shows whether the latch takes the value before or after the increment.

// File: rtl/ts_pkg.sv
package ts_pkg;
  localparam int CODE_W = 8;
  localparam logic [CODE_W-1:0] CODE_NULL   = 8'h00;
  localparam logic [CODE_W-1:0] CODE_SHIFT0 = 8'h70;
  localparam logic [CODE_W-1:0] CODE_SHIFT1 = 8'h71;
  localparam logic [CODE_W-1:0] CODE_TICK   = 8'h7C;
  localparam logic [CODE_W-1:0] CODE_RESET  = 8'h7D;

  typedef enum logic [1:0] {
    SRC_EVENT  = 2'd0,
    SRC_DIVCLK = 2'd1,
    SRC_DBUS   = 2'd2,
    SRC_HALT   = 2'd3
  } cnt_src_e;
endpackage

// File: rtl/ts_seconds.sv
module ts_seconds
  import ts_pkg::*;
#(
  parameter int TIME_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code,
  output logic [TIME_W-1:0] secs
);
  logic [TIME_W-1:0] shift_q;
  logic [TIME_W-1:0] secs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      secs_q  <= '0;
    end else begin
      unique case (code)
        CODE_SHIFT0: shift_q <= {shift_q[TIME_W-2:0], 1'b0};
        CODE_SHIFT1: shift_q <= {shift_q[TIME_W-2:0], 1'b1};
        CODE_RESET:  secs_q  <= shift_q;
        default: ;
      endcase
    end
  end

  assign secs = secs_q;

  // R3: promotion presents the assembled word one edge later
  assert_promote_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (code == CODE_RESET) |=> (secs == $past(shift_q)));
  // R2: shift codes never disturb the published seconds
  assert_shift_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (code == CODE_SHIFT0 || code == CODE_SHIFT1) |=> $stable(secs));
  // R2: the new LSB follows the code
  assert_shift_lsb_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (code == CODE_SHIFT1) |=> shift_q[0]);
  // R8: null code leaves both words untouched
  assert_null_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (code == CODE_NULL) |=> ($stable(shift_q) && $stable(secs)));
endmodule

// File: rtl/ts_counter.sv
module ts_counter
  import ts_pkg::*;
#(
  parameter int TIME_W   = 32,
  parameter int FREE_DIV = 4,
  parameter int DBUS_W   = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [CODE_W-1:0]         code,
  input  cnt_src_e                  src,
  input  logic [DBUS_W-1:0]         dbus,
  input  logic [$clog2(DBUS_W)-1:0] dbus_sel,
  output logic [TIME_W-1:0]         cnt
);
  localparam int PRE_W = (FREE_DIV > 2) ? $clog2(FREE_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(FREE_DIV - 1);

  logic [TIME_W-1:0] cnt_q;
  logic [PRE_W-1:0]  pre_q;
  logic              div_tick;
  logic              bus_s1, bus_s2, bus_rise;
  logic              step;
  logic              clr;

  assign clr      = (code == CODE_RESET);
  assign div_tick = (pre_q == PRE_LAST);
  assign bus_rise = bus_s1 & ~bus_s2;

  // two-stage edge detector on the chosen bus bit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_s1 <= 1'b0;
      bus_s2 <= 1'b0;
    end else begin
      bus_s1 <= dbus[dbus_sel];
      bus_s2 <= bus_s1;
    end
  end

  // free-running divider, re-phased by the reset code
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pre_q <= '0;
    else if (clr || div_tick)  pre_q <= '0;
    else                       pre_q <= pre_q + 1'b1;
  end

  always_comb begin
    unique case (src)
      SRC_EVENT:  step = (code == CODE_TICK);
      SRC_DIVCLK: step = div_tick;
      SRC_DBUS:   step = bus_rise;
      default:    step = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clr)   cnt_q <= '0;
    else if (step)  cnt_q <= cnt_q + TIME_W'(1);
  end

  assign cnt = cnt_q;

  // R3: reset code clears regardless of source
  assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));
  // R4: in event mode only increment and reset codes move the counter
  assert_event_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (src == SRC_EVENT && code != CODE_TICK && !clr) |=> $stable(cnt));
  // R4: the counter never jumps by more than one
  assert_single_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (cnt == $past(cnt) || cnt == $past(cnt) + TIME_W'(1)));
  // R12: halted source freezes the counter
  assert_halt_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (src == SRC_HALT && !clr) |=> $stable(cnt));
endmodule

// File: rtl/ts_event_fifo.sv
module ts_event_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 72
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data,
  output logic         full,
  output logic         empty,
  output logic         overflow
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wr_ptr, rd_ptr;
  logic [AW:0]  used;
  logic         accept, take;

  assign used      = wr_ptr - rd_ptr;
  assign full      = (used == (AW+1)'(DEPTH));
  assign empty     = (wr_ptr == rd_ptr);
  assign out_valid = !empty;
  assign out_data  = mem[rd_ptr[AW-1:0]];
  assign accept    = push && !full;
  assign take      = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (accept) mem[wr_ptr[AW-1:0]] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      overflow <= 1'b0;
    end else begin
      if (accept)        wr_ptr   <= wr_ptr + 1'b1;
      if (take)          rd_ptr   <= rd_ptr + 1'b1;
      if (push && full)  overflow <= 1'b1;
    end
  end

  // R10: a push into a full FIFO is dropped and flagged
  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full) |=> (overflow && wr_ptr == $past(wr_ptr)));
  // R10: occupancy stays within depth
  assert_depth_R10: assert property (@(posedge clk) disable iff (!rst_n)
    used <= (AW+1)'(DEPTH));
  // R10: overflow flag is sticky
  assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  // R9: stalled head is held
  assert_head_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/evt_timestamp_unit.sv
module evt_timestamp_unit
  import ts_pkg::*;
#(
  parameter int TIME_W     = 32,
  parameter int FIFO_DEPTH = 16,
  parameter int FREE_DIV   = 4,
  parameter int DBUS_W     = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [7:0]                evt_code,
  input  logic                      evt_capture,
  input  logic [1:0]                cnt_src,
  input  logic [DBUS_W-1:0]         dbus,
  input  logic [$clog2(DBUS_W)-1:0] dbus_sel,
  input  logic                      sw_latch,
  output logic [TIME_W-1:0]         secs,
  output logic [TIME_W-1:0]         ts_count,
  output logic [TIME_W-1:0]         latch_secs,
  output logic [TIME_W-1:0]         latch_count,
  output logic                      fifo_valid,
  input  logic                      fifo_ready,
  output logic [7:0]                fifo_code,
  output logic [TIME_W-1:0]         fifo_secs,
  output logic [TIME_W-1:0]         fifo_count,
  output logic                      fifo_full,
  output logic                      fifo_empty,
  output logic                      fifo_overflow
);
  localparam int ENTRY_W = CODE_W + 2 * TIME_W;

  logic               cap_push;
  logic [ENTRY_W-1:0] cap_word;
  logic [ENTRY_W-1:0] head_word;

  ts_seconds #(.TIME_W(TIME_W)) u_seconds (
    .clk  (clk),
    .rst_n(rst_n),
    .code (evt_code),
    .secs (secs)
  );

  ts_counter #(.TIME_W(TIME_W), .FREE_DIV(FREE_DIV), .DBUS_W(DBUS_W)) u_counter (
    .clk     (clk),
    .rst_n   (rst_n),
    .code    (evt_code),
    .src     (cnt_src_e'(cnt_src)),
    .dbus    (dbus),
    .dbus_sel(dbus_sel),
    .cnt     (ts_count)
  );

  assign cap_push = evt_capture && (evt_code != CODE_NULL);
  assign cap_word = {evt_code, secs, ts_count};

  ts_event_fifo #(.DEPTH(FIFO_DEPTH), .W(ENTRY_W)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (cap_push),
    .push_data(cap_word),
    .out_valid(fifo_valid),
    .out_ready(fifo_ready),
    .out_data (head_word),
    .full     (fifo_full),
    .empty    (fifo_empty),
    .overflow (fifo_overflow)
  );

  assign fifo_code  = head_word[ENTRY_W-1 -: CODE_W];
  assign fifo_secs  = head_word[2*TIME_W-1 -: TIME_W];
  assign fifo_count = head_word[TIME_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_secs  <= '0;
      latch_count <= '0;
    end else if (sw_latch) begin
      latch_secs  <= secs;
      latch_count <= ts_count;
    end
  end

  // R11: software latch takes the pre-edge time words
  assert_latch_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sw_latch |=> (latch_count == $past(ts_count) && latch_secs == $past(secs)));
  // R8: null code with capture flag does not add an entry
  assert_null_nopush_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_code == CODE_NULL && fifo_empty) |=> fifo_empty);
  // R9: valid and empty are complementary
  assert_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_valid != fifo_empty);
endmodule

// File: tb/evt_timestamp_unit_bench.sv
module evt_timestamp_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  evt_code = 8'h00;
  logic        evt_capture = 1'b0;
  logic [1:0]  cnt_src = 2'd0;
  logic [7:0]  dbus = 8'h00;
  logic [2:0]  dbus_sel = 3'd0;
  logic        sw_latch = 1'b0;
  logic        fifo_ready = 1'b0;
  logic [31:0] secs, ts_count, latch_secs, latch_count, fifo_secs, fifo_count;
  logic [7:0]  fifo_code;
  logic        fifo_valid, fifo_full, fifo_empty, fifo_overflow;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evt_timestamp_unit u_evt_timestamp_unit (
    .clk(clk), .rst_n(rst_n), .evt_code(evt_code), .evt_capture(evt_capture),
    .cnt_src(cnt_src), .dbus(dbus), .dbus_sel(dbus_sel), .sw_latch(sw_latch),
    .secs(secs), .ts_count(ts_count), .latch_secs(latch_secs),
    .latch_count(latch_count), .fifo_valid(fifo_valid), .fifo_ready(fifo_ready),
    .fifo_code(fifo_code), .fifo_secs(fifo_secs), .fifo_count(fifo_count),
    .fifo_full(fifo_full), .fifo_empty(fifo_empty), .fifo_overflow(fifo_overflow)
  );

  // {code, capture, expected secs after edge, expected count after edge}
  localparam logic [72:0] VEC [NVEC] = '{
    {8'h70, 1'b0, 32'd0, 32'd0},
    {8'h71, 1'b0, 32'd0, 32'd0},
    {8'h7C, 1'b0, 32'd0, 32'd1},
    {8'h71, 1'b0, 32'd0, 32'd1},
    {8'h7C, 1'b0, 32'd0, 32'd2},
    {8'h00, 1'b1, 32'd0, 32'd2},
    {8'h7D, 1'b0, 32'd3, 32'd0},
    {8'h7C, 1'b0, 32'd3, 32'd1},
    {8'h7C, 1'b1, 32'd3, 32'd2},
    {8'h05, 1'b1, 32'd3, 32'd2},
    {8'h70, 1'b0, 32'd3, 32'd2},
    {8'h7D, 1'b0, 32'd6, 32'd0}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // called at a falling edge; applies one cycle and returns at the next falling edge
  task automatic step(input logic [7:0] c, input logic cap);
    evt_code = c;
    evt_capture = cap;
    @(posedge clk);
    @(negedge clk);
    evt_code = 8'h00;
    evt_capture = 1'b0;
    sw_latch = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 secs", 64'(secs), 0);
    chk("R1 count", 64'(ts_count), 0);
    chk("R1 latch", 64'({latch_secs, latch_count}), 0);
    chk("R1 flags", 64'({fifo_empty, fifo_full, fifo_valid, fifo_overflow}), 64'b1000);

    // vector walk, event-counting mode: R2 R3 R4 R7 R8
    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][72:65], VEC[i][64]);
      chk($sformatf("R2 R3 vec%0d secs", i), 64'(secs), 64'(VEC[i][63:32]));
      chk($sformatf("R4 R3 vec%0d count", i), 64'(ts_count), 64'(VEC[i][31:0]));
    end

    // R7 R8: exactly two entries captured with pre-edge time words
    chk("R7 head code", 64'(fifo_code), 64'h7C);
    chk("R7 head time", 64'({fifo_secs, fifo_count}), {32'd3, 32'd1});
    // R9: stall holds the head
    for (int i = 0; i < 3; i++) step(8'h00, 1'b1);
    chk("R9 stalled head", 64'({fifo_valid, fifo_code}), {55'd0, 1'b1, 8'h7C});
    fifo_ready = 1'b1;
    step(8'h00, 1'b0);
    chk("R7 second entry", 64'({fifo_code, fifo_secs[7:0], fifo_count[7:0]}), 64'h050302);
    step(8'h00, 1'b0);
    chk("R8 no null entry", 64'(fifo_empty), 1);
    fifo_ready = 1'b0;

    // R11: software latch on an incrementing cycle
    step(8'h7C, 1'b0);
    step(8'h7C, 1'b0);
    step(8'h7C, 1'b0);
    sw_latch = 1'b1;
    step(8'h7C, 1'b0);
    chk("R11 latch count", 64'(latch_count), 3);
    chk("R11 latch secs", 64'(latch_secs), 6);
    chk("R11 no fifo write", 64'(fifo_empty), 1);

    // R10: fill past depth
    for (int i = 0; i < 16; i++) step(8'h40 + 8'(i), 1'b1);
    chk("R10 full at 16", 64'({fifo_full, fifo_overflow}), 64'b10);
    step(8'h50, 1'b1);
    chk("R10 overflow set", 64'({fifo_full, fifo_overflow}), 64'b11);
    chk("R7 entry time", 64'({fifo_secs, fifo_count}), {32'd6, 32'd4});
    fifo_ready = 1'b1;
    for (int i = 0; i < 16; i++) begin
      chk($sformatf("R9 order %0d", i), 64'(fifo_code), 64'(8'h40 + 8'(i)));
      step(8'h00, 1'b0);
    end
    chk("R10 dropped entry absent", 64'(fifo_empty), 1);
    chk("R10 overflow sticky", 64'(fifo_overflow), 1);
    fifo_ready = 1'b0;

    // R5: divided clock, 0x7C ignored
    cnt_src = 2'd1;
    step(8'h7D, 1'b0);
    chk("R3 clear in div mode", 64'(ts_count), 0);
    step(8'h00, 1'b0);
    step(8'h7C, 1'b0);
    step(8'h00, 1'b0);
    chk("R5 no step before divide", 64'(ts_count), 0);
    step(8'h00, 1'b0);
    chk("R5 first divided step", 64'(ts_count), 1);
    for (int i = 0; i < 4; i++) step(8'h00, 1'b0);
    chk("R5 second divided step", 64'(ts_count), 2);

    // R6: bus clock on bit 5
    cnt_src = 2'd2;
    dbus_sel = 3'd5;
    step(8'h7D, 1'b0);
    dbus[5] = 1'b1;
    step(8'h00, 1'b0);
    chk("R6 edge not yet counted", 64'(ts_count), 0);
    step(8'h00, 1'b0);
    chk("R6 edge counted", 64'(ts_count), 1);
    dbus[2] = 1'b1;
    step(8'h7C, 1'b0);
    step(8'h00, 1'b0);
    chk("R6 level and other bit ignored", 64'(ts_count), 1);
    dbus[5] = 1'b0;
    step(8'h00, 1'b0);
    dbus[5] = 1'b1;
    step(8'h00, 1'b0);
    step(8'h00, 1'b0);
    chk("R6 second edge", 64'(ts_count), 2);

    // R12: halt, then reset code still clears
    cnt_src = 2'd3;
    dbus[5] = 1'b0;
    step(8'h7C, 1'b0);
    step(8'h00, 1'b0);
    chk("R12 halted", 64'(ts_count), 2);
    step(8'h7D, 1'b0);
    chk("R12 R3 clear while halted", 64'(ts_count), 0);
    chk("R3 secs repromoted", 64'(secs), 6);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule